// File: doc/BRIEF.md
# Vector Sign-Bit Mask Extractor

This unit turns a 512-bit packed vector into a 64-bit predicate mask. Each mask bit copies the top bit (the sign bit) of one element of the vector. A small descriptor goes in alongside the vector. It holds an opcode byte, a width-select bit, a 2-bit length code and a 4-bit spare field. From these the unit picks the element width (8, 16, 32 or 64 bits) and the active vector length (128, 256 or 512 bits).

Mask positions past the last active element always read as zero. A descriptor the unit does not accept raises a fault instead of producing a mask. The unit sits next to a SIMD datapath. Each operation is offered with a single valid strobe, and the result comes back one clock later, also with a single valid strobe.

Top module: `vmask_extract`

## Requirements
- R1: Opcode 0x29 with the width-select bit at 0 treats the vector as bytes: mask bit j is source bit 8*j+7.
- R2: Opcode 0x29 with the width-select bit at 1 treats the vector as 16-bit elements: mask bit j is source bit 16*j+15.
- R3: Opcode 0x39 with the width-select bit at 0 treats the vector as 32-bit elements: mask bit j is source bit 32*j+31.
- R4: Opcode 0x39 with the width-select bit at 1 treats the vector as 64-bit elements: mask bit j is source bit 64*j+63.
- R5: Length code 2'b00, 2'b01 and 2'b10 select 128, 256 and 512 active bits. Mask bits at index VL/element-width and above are zero, and source bits at or above VL have no effect on the mask.
- R6: A spare field other than 4'b1111 raises the fault flag and forces the mask to zero.
- R7: Length code 2'b11 raises the fault flag and forces the mask to zero.
- R8: An opcode other than 0x29 or 0x39 raises the fault flag and forces the mask to zero.
- R9: A result appears exactly one clock after each cycle with in_valid high. out_valid is high for one cycle per accepted input and low after any cycle without one. A faulting input still produces out_valid.
- R10: A synchronous active-low reset clears out_valid, out_mask and out_fault.
- R11: Between results, out_mask and out_fault hold the values of the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation offered this cycle |
| in_opcode | input | 8 | Operation byte (0x29 or 0x39) |
| in_wide | input | 1 | Width-select bit |
| in_vlen | input | 2 | Active length code |
| in_spare | input | 4 | Spare field, must be 4'b1111 |
| in_src | input | 512 | Packed source vector |
| out_valid | output | 1 | Result strobe |
| out_mask | output | 64 | Sign-bit mask |
| out_fault | output | 1 | Undefined-operation fault |

## Verification
The bench checks the clipping boundary at each length for every element width. A unit that sized the clip by bytes alone would leak random upper bits into the mask for wide elements. A vector whose only set bits lie above the active length must give a zero mask; a design that scanned the whole vector would set mask bits there. Each of the three fault causes is shown one at a time, following a good result. A design that forgot to zero the mask, or that dropped out_valid on a fault, is exposed by this. Back-to-back inputs and idle gaps catch extra latency, stuck strobes and outputs that drift while idle.

// File: rtl/vmask_pkg.sv
package vmask_pkg;

   typedef enum logic [1:0] {
      ESZ_B = 2'd0,
      ESZ_H = 2'd1,
      ESZ_S = 2'd2,
      ESZ_D = 2'd3
   } esz_e;

   typedef struct packed {
      logic [7:0] opcode;
      logic       wide;
      logic [1:0] vlen;
      logic [3:0] spare;
   } desc_t;

   localparam logic [3:0] SPARE_OK = 4'b1111;
   localparam logic [1:0] VLEN_BAD = 2'b11;
   localparam int         NUM_ESZ  = 4;
   localparam int         MIN_EW   = 8;

endpackage

// File: rtl/vmask_decode.sv
module vmask_decode
   import vmask_pkg::*;
#(
   parameter int         MIN_VL = 128,
   parameter int         CNT_W  = 7,
   parameter logic [7:0] OPC_A  = 8'h29,
   parameter logic [7:0] OPC_B  = 8'h39
) (
   input  desc_t             desc,
   output esz_e              esz,
   output logic [CNT_W-1:0]  count,
   output logic              fault
);

   logic is_a, is_b;
   int   vl_bits;

   assign is_a = (desc.opcode == OPC_A);
   assign is_b = (desc.opcode == OPC_B);
   assign esz  = esz_e'({is_b, desc.wide});

   always_comb begin
      vl_bits = MIN_VL << desc.vlen;
      count   = CNT_W'(vl_bits >> ($clog2(MIN_EW) + int'(esz)));
   end

   assign fault = !(is_a || is_b)
                || (desc.vlen == VLEN_BAD)
                || (desc.spare != SPARE_OK);

endmodule

// File: rtl/vmask_lanes.sv
module vmask_lanes
   import vmask_pkg::*;
#(
   parameter int VEC_W  = 512,
   parameter int MASK_W = 64,
   parameter int CNT_W  = 7
) (
   input  logic [VEC_W-1:0]  src,
   input  esz_e              esz,
   input  logic [CNT_W-1:0]  count,
   output logic [MASK_W-1:0] mask
);

   logic [MASK_W-1:0] cand [NUM_ESZ];
   logic [MASK_W-1:0] picked;
   logic [MASK_W-1:0] keep;

   for (genvar g = 0; g < NUM_ESZ; g++) begin : g_width
      localparam int EW = MIN_EW << g;
      localparam int NE = VEC_W / EW;
      logic [MASK_W-1:0] lane_msb;
      always_comb begin
         lane_msb = '0;
         for (int j = 0; j < NE; j++) lane_msb[j] = src[j*EW + EW - 1];
      end
      assign cand[g] = lane_msb;
   end

   assign picked = cand[esz];

   always_comb begin
      for (int j = 0; j < MASK_W; j++) keep[j] = (CNT_W'(j) < count);
   end

   assign mask = picked & keep;

endmodule

// File: rtl/vmask_extract.sv
module vmask_extract
   import vmask_pkg::*;
#(
   parameter int         VEC_W  = 512,
   parameter int         MIN_VL = 128,
   parameter logic [7:0] OPC_A  = 8'h29,
   parameter logic [7:0] OPC_B  = 8'h39,
   localparam int        MASK_W = VEC_W / MIN_EW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_opcode,
   input  logic              in_wide,
   input  logic [1:0]        in_vlen,
   input  logic [3:0]        in_spare,
   input  logic [VEC_W-1:0]  in_src,
   output logic              out_valid,
   output logic [MASK_W-1:0] out_mask,
   output logic              out_fault
);

   localparam int CNT_W = $clog2(MASK_W) + 1;

   if (VEC_W != MIN_VL * 4) begin : g_bad_len
      $error("vmask_extract: VEC_W must be four times MIN_VL");
   end
   if (MIN_VL % 64 != 0) begin : g_bad_min
      $error("vmask_extract: MIN_VL must hold whole 64-bit elements");
   end

   desc_t             desc;
   esz_e              esz;
   logic [CNT_W-1:0]  count;
   logic              fault;
   logic [MASK_W-1:0] lane_mask;

   assign desc = '{opcode: in_opcode, wide: in_wide, vlen: in_vlen, spare: in_spare};

   vmask_decode #(
      .MIN_VL (MIN_VL),
      .CNT_W  (CNT_W),
      .OPC_A  (OPC_A),
      .OPC_B  (OPC_B)
   ) u_dec (
      .desc  (desc),
      .esz   (esz),
      .count (count),
      .fault (fault)
   );

   vmask_lanes #(
      .VEC_W  (VEC_W),
      .MASK_W (MASK_W),
      .CNT_W  (CNT_W)
   ) u_lanes (
      .src   (in_src),
      .esz   (esz),
      .count (count),
      .mask  (lane_mask)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_mask  <= '0;
         out_fault <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_fault <= fault;
            out_mask  <= fault ? '0 : lane_mask;
         end
      end
   end

endmodule

// File: rtl/vmask_extract_chk.sv
module vmask_extract_chk #(
   parameter int         VEC_W  = 512,
   parameter logic [7:0] OPC_A  = 8'h29,
   parameter logic [7:0] OPC_B  = 8'h39,
   localparam int        MASK_W = VEC_W / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [7:0]        in_opcode,
   input logic              in_wide,
   input logic [1:0]        in_vlen,
   input logic [3:0]        in_spare,
   input logic [31:0]       in_src_lo,
   input logic              out_valid,
   input logic [MASK_W-1:0] out_mask,
   input logic              out_fault
);

   logic good_desc;
   assign good_desc = (in_spare == 4'hF) && (in_vlen != 2'b11)
                    && (in_opcode == OPC_A || in_opcode == OPC_B);

   a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   a_r6_fault_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
      out_fault |-> (out_mask == '0));

   a_r6_spare: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_spare != 4'hF) |=> out_fault);

   a_r7_vlen: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_vlen == 2'b11) |=> out_fault);

   a_r8_opcode: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_opcode != OPC_A && in_opcode != OPC_B) |=> out_fault);

   a_r5_clip128: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_vlen == 2'b00) |=> (out_mask[MASK_W-1:MASK_W/4] == '0));

   a_r5_clip256: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_vlen == 2'b01) |=> (out_mask[MASK_W-1:MASK_W/2] == '0));

   a_r4_qword_clip: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_opcode == OPC_B && in_wide) |=> (out_mask[MASK_W-1:MASK_W/8] == '0));

   a_r1_byte_lane0: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && good_desc && in_opcode == OPC_A && !in_wide)
      |=> (out_mask[0] == $past(in_src_lo[7])));

   a_r2_half_lane1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && good_desc && in_opcode == OPC_A && in_wide)
      |=> (out_mask[1] == $past(in_src_lo[31])));

   a_r3_word_lane0: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && good_desc && in_opcode == OPC_B && !in_wide)
      |=> (out_mask[0] == $past(in_src_lo[31])));

   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_mask) && $stable(out_fault)));

endmodule

bind vmask_extract vmask_extract_chk #(
   .VEC_W (VEC_W),
   .OPC_A (OPC_A),
   .OPC_B (OPC_B)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_opcode (in_opcode),
   .in_wide   (in_wide),
   .in_vlen   (in_vlen),
   .in_spare  (in_spare),
   .in_src_lo (in_src[31:0]),
   .out_valid (out_valid),
   .out_mask  (out_mask),
   .out_fault (out_fault)
);

// File: tb/sim_vmask_extract.sv
`timescale 1ns/1ps
module sim_vmask_extract;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [7:0]   in_opcode = 8'h00;
   logic         in_wide = 1'b0;
   logic [1:0]   in_vlen = 2'b00;
   logic [3:0]   in_spare = 4'hF;
   logic [511:0] in_src = '0;
   logic         out_valid;
   logic [63:0]  out_mask;
   logic         out_fault;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   vmask_extract u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_opcode (in_opcode),
      .in_wide   (in_wide),
      .in_vlen   (in_vlen),
      .in_spare  (in_spare),
      .in_src    (in_src),
      .out_valid (out_valid),
      .out_mask  (out_mask),
      .out_fault (out_fault)
   );

   typedef struct packed {
      logic [7:0]  op;
      logic        w;
      logic [1:0]  vl;
      logic [3:0]  sp;
      logic [31:0] seed;
      logic        flt;
   } vec_t;

   localparam int NVEC = 18;
   localparam vec_t VECS [NVEC] = '{
      '{8'h29, 1'b0, 2'b00, 4'hF, 32'h1234_5678, 1'b0},  // R1 R5
      '{8'h29, 1'b0, 2'b01, 4'hF, 32'h0BAD_F00D, 1'b0},  // R1 R5
      '{8'h29, 1'b0, 2'b10, 4'hF, 32'hDEAD_BEEF, 1'b0},  // R1
      '{8'h29, 1'b1, 2'b00, 4'hF, 32'h1357_9BDF, 1'b0},  // R2 R5
      '{8'h29, 1'b1, 2'b01, 4'hF, 32'h2468_ACE0, 1'b0},  // R2 R5
      '{8'h29, 1'b1, 2'b10, 4'hF, 32'hCAFE_0001, 1'b0},  // R2
      '{8'h39, 1'b0, 2'b00, 4'hF, 32'h0F0F_1E1E, 1'b0},  // R3 R5
      '{8'h39, 1'b0, 2'b01, 4'hF, 32'h7777_1111, 1'b0},  // R3 R5
      '{8'h39, 1'b0, 2'b10, 4'hF, 32'hA5A5_5A5A, 1'b0},  // R3
      '{8'h39, 1'b1, 2'b00, 4'hF, 32'h9999_0003, 1'b0},  // R4 R5
      '{8'h39, 1'b1, 2'b01, 4'hF, 32'h3141_5926, 1'b0},  // R4 R5
      '{8'h39, 1'b1, 2'b10, 4'hF, 32'h2718_2818, 1'b0},  // R4
      '{8'h29, 1'b0, 2'b10, 4'hE, 32'h1111_2222, 1'b1},  // R6
      '{8'h39, 1'b1, 2'b01, 4'h0, 32'h3333_4444, 1'b1},  // R6
      '{8'h29, 1'b0, 2'b11, 4'hF, 32'h5555_6666, 1'b1},  // R7
      '{8'h39, 1'b1, 2'b11, 4'hF, 32'h7777_8888, 1'b1},  // R7
      '{8'h28, 1'b0, 2'b10, 4'hF, 32'h9999_AAAA, 1'b1},  // R8
      '{8'h3A, 1'b1, 2'b00, 4'hF, 32'hBBBB_CCCC, 1'b1}   // R8
   };

   function automatic logic [511:0] mk_src(logic [31:0] seed);
      logic [511:0] v;
      logic [31:0]  x;
      x = seed;
      for (int k = 0; k < 16; k++) begin
         x = x ^ (x << 13);
         x = x ^ (x >> 17);
         x = x ^ (x << 5);
         v[k*32 +: 32] = x;
      end
      return v;
   endfunction

   function automatic logic [63:0] ref_mask(logic [7:0] op, logic w, logic [1:0] vl,
                                            logic [511:0] s);
      logic [63:0] m;
      int ew, cnt;
      ew  = 8 << int'({(op == 8'h39), w});
      cnt = (128 << vl) / ew;
      m = '0;
      for (int j = 0; j < 64; j++)
         if (j < cnt) m[j] = s[j*ew + ew - 1];
      return m;
   endfunction

   task automatic check(string req, logic exp_v, logic [63:0] exp_m, logic exp_f);
      checks++;
      if (out_valid !== exp_v || out_mask !== exp_m || out_fault !== exp_f) begin
         failures++;
         $display("FAIL %s: actual valid=%0b mask=%h fault=%0b expected valid=%0b mask=%h fault=%0b",
                  req, out_valid, out_mask, out_fault, exp_v, exp_m, exp_f);
      end
   endtask

   task automatic issue(logic [7:0] op, logic w, logic [1:0] vl, logic [3:0] sp,
                        logic [511:0] s);
      @(negedge clk);
      in_opcode = op; in_wide = w; in_vlen = vl; in_spare = sp; in_src = s;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      logic [511:0] s;
      logic [63:0]  last;
      repeat (3) @(negedge clk);
      check("R10 reset", 1'b0, 64'h0, 1'b0);
      rst_n = 1'b1;

      // table walk
      for (int i = 0; i < NVEC; i++) begin
         s = mk_src(VECS[i].seed);
         issue(VECS[i].op, VECS[i].w, VECS[i].vl, VECS[i].sp, s);
         check($sformatf("R1-table-%0d", i), 1'b1,
               VECS[i].flt ? 64'h0 : ref_mask(VECS[i].op, VECS[i].w, VECS[i].vl, s),
               VECS[i].flt);
      end

      // all-ones vectors with hand values
      issue(8'h29, 1'b0, 2'b10, 4'hF, {512{1'b1}});
      check("R1 bytes 512", 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
      issue(8'h29, 1'b1, 2'b01, 4'hF, {512{1'b1}});
      check("R2 halves 256", 1'b1, 64'h0000_0000_0000_FFFF, 1'b0);
      issue(8'h39, 1'b0, 2'b10, 4'hF, {512{1'b1}});
      check("R3 words 512", 1'b1, 64'h0000_0000_0000_FFFF, 1'b0);
      issue(8'h39, 1'b1, 2'b00, 4'hF, {512{1'b1}});
      check("R4 dwords 128", 1'b1, 64'h0000_0000_0000_0003, 1'b0);

      // bits above VL ignored
      issue(8'h29, 1'b0, 2'b00, 4'hF, {{384{1'b1}}, 128'h0});
      check("R5 upper source ignored", 1'b1, 64'h0, 1'b0);
      issue(8'h29, 1'b0, 2'b01, 4'hF, {{256{1'b1}}, 128'h0, 128'h80});
      check("R5 upper source ignored 256", 1'b1, 64'h0000_0000_0000_0001, 1'b0);

      // single lane positions
      issue(8'h39, 1'b1, 2'b10, 4'hF, 512'h1 << 511);
      check("R4 top lane", 1'b1, 64'h80, 1'b0);
      issue(8'h29, 1'b1, 2'b10, 4'hF, 512'h1 << 495);
      check("R2 lane 30", 1'b1, 64'h4000_0000, 1'b0);

      // fault after a good result: mask must be zero, valid still strobes
      issue(8'h29, 1'b0, 2'b10, 4'hF, {512{1'b1}});
      issue(8'h29, 1'b0, 2'b10, 4'h7, {512{1'b1}});
      check("R6 spare fault", 1'b1, 64'h0, 1'b1);
      issue(8'h29, 1'b0, 2'b10, 4'hF, {512{1'b1}});
      issue(8'h29, 1'b0, 2'b11, 4'hF, {512{1'b1}});
      check("R7 length fault", 1'b1, 64'h0, 1'b1);
      issue(8'h29, 1'b0, 2'b10, 4'hF, {512{1'b1}});
      issue(8'h00, 1'b0, 2'b10, 4'hF, {512{1'b1}});
      check("R8 opcode fault", 1'b1, 64'h0, 1'b1);

      // hold while idle, with inputs moving
      issue(8'h39, 1'b0, 2'b01, 4'hF, {512{1'b1}});
      check("R9 result", 1'b1, 64'hFF, 1'b0);
      last = 64'hFF;
      in_opcode = 8'h29; in_vlen = 2'b10; in_src = '0;
      @(negedge clk);
      check("R11 hold idle", 1'b0, last, 1'b0);
      @(negedge clk);
      check("R9 no spurious valid", 1'b0, last, 1'b0);

      // back-to-back inputs
      @(negedge clk);
      in_opcode = 8'h39; in_wide = 1'b1; in_vlen = 2'b10; in_spare = 4'hF;
      in_src = {512{1'b1}}; in_valid = 1'b1;
      @(negedge clk);
      check("R9 first of pair", 1'b1, 64'hFF, 1'b0);
      in_opcode = 8'h29; in_wide = 1'b0; in_vlen = 2'b00; in_src = {512{1'b1}};
      @(negedge clk);
      in_valid = 1'b0;
      check("R9 second of pair", 1'b1, 64'hFFFF, 1'b0);

      // reset after a result
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 reset clears", 1'b0, 64'h0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 idle after reset", 1'b0, 64'h0, 1'b0);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule